// File: doc/BRIEF.md
# Framed Byte Catcher with Host Serial Read-Out

This block sits behind a 1200 baud FSK demodulator and its bit-timing recovery. Once per bit period a timing pulse marks the middle of the current bit, and the block frames the demodulated stream. A low bit seen while idle opens a word. The next eight bits are collected first-bit-first. The bit that follows them is the closing (stop) slot and is discarded. The start and stop bits are never stored. Only the eight data bits are kept, in a one-byte holding register.

When the eighth data bit arrives, the byte is copied into the holding register and an active-low ready line drops to signal the host. The host then pulls the bits out one at a time on a single data line, using a slow read clock of its own. That clock is brought into the system clock domain through a two-stage synchroniser and a rising-edge detector. The ready line releases on the host's first read edge or after half a bit period, whichever comes first. A sticky overrun flag records that a byte was replaced before the host had read all of it.

Top module: `byte_buffer_rx`

## Requirements
- R1: After reset, `rdy_n` is 1, `overrun` is 0 and `host_data` is 1.
- R2: A tick with `rx_bit` 0 while idle starts a word. On the tick of the eighth data bit that follows, the byte is loaded. From the next cycle `rdy_n` is 0 and `host_data` shows the first data bit received, which is bit 0 of the byte.
- R3: Each rising edge of `host_clk` moves `host_data` to the next received bit (bit 1, then bit 2, and so on). The new bit appears three system clock cycles after the edge.
- R4: A read edge that arrives while `rdy_n` is 0 returns `rdy_n` to 1 in the same cycle that `host_data` advances.
- R5: With no read edge, `rdy_n` stays 0 for exactly `HALF_CYC` system cycles after the load and then returns to 1.
- R6: After the eighth read edge, `host_data` holds bit 7. Further read edges change nothing. A byte that has been read out completely does not cause an overrun when the next byte loads.
- R7: While `carrier_ok` is 0, ticks are ignored and any partly received word is discarded. No byte is loaded, `rdy_n` does not fall and `host_data` is unchanged.
- R8: The tick after the eighth data bit is the stop slot. It returns the framer to idle whatever its value, and is never taken as a start bit.
- R9: A load that happens before all eight bits of the held byte have been read sets `overrun` to 1. The flag stays at 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_tick | input | 1 | One-cycle pulse at the middle of each bit period |
| rx_bit | input | 1 | Demodulated bit (mark = 1, space = 0) |
| carrier_ok | input | 1 | Carrier qualified; ticks are ignored while this is 0 |
| host_clk | input | 1 | Host read clock, asynchronous to `clk` |
| host_data | output | 1 | Serial data bit presented to the host |
| rdy_n | output | 1 | Byte ready, active low |
| overrun | output | 1 | Sticky flag: a byte was replaced before it was fully read |

## Verification
A load takes effect on the clock edge that samples the eighth data tick, so `rdy_n` and `host_data` are sampled on the falling edge that follows. A read edge acts on the third rising clock edge after `host_clk` rises. The bench therefore checks the cycle before that edge, where nothing has moved yet, and then checks the cycle right after it. The half-bit release is checked at two points: one cycle before the `HALF_CYC` count ends, where `rdy_n` must still be 0, and on the count itself, where it must be 1. Read pulses hold each level for six cycles, and every bit check is made once the pulse has settled.

// File: rtl/byte_buffer_rx.sv
module byte_buffer_rx #(
  parameter int DBITS    = 8,
  parameter int HALF_CYC = 20833
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_tick,
  input  logic rx_bit,
  input  logic carrier_ok,
  input  logic host_clk,
  output logic host_data,
  output logic rdy_n,
  output logic overrun
);
  localparam int CW = $clog2(DBITS + 1);
  localparam int IW = $clog2(DBITS);
  localparam int HW = $clog2(HALF_CYC + 1);

  logic [2:0]       hs;
  logic             busy;
  logic [CW-1:0]    pos;
  logic [DBITS-1:0] asm_q, byte_q;
  logic [CW-1:0]    cnt;
  logic [HW-1:0]    hc;
  logic [IW-1:0]    sel;

  wire              rd_rise = hs[1] & ~hs[2];
  wire [DBITS-1:0]  asm_nx  = {rx_bit, asm_q[DBITS-1:1]};
  wire              load_w  = bit_tick & carrier_ok & busy & (pos == CW'(DBITS - 1));
  wire              drained = (cnt == CW'(DBITS));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) hs <= '0;
    else        hs <= {hs[1:0], host_clk};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      busy  <= 1'b0;
      pos   <= '0;
      asm_q <= '0;
    end else if (!carrier_ok) begin
      busy <= 1'b0;
      pos  <= '0;
    end else if (bit_tick) begin
      if (!busy) begin
        if (!rx_bit) begin
          busy <= 1'b1;
          pos  <= '0;
        end
      end else if (pos == CW'(DBITS)) begin
        busy <= 1'b0;
      end else begin
        asm_q <= asm_nx;
        pos   <= pos + 1'b1;
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      byte_q  <= '1;
      cnt     <= CW'(DBITS);
      rdy_n   <= 1'b1;
      hc      <= '0;
      overrun <= 1'b0;
    end else if (load_w) begin
      byte_q <= asm_nx;
      cnt    <= '0;
      rdy_n  <= 1'b0;
      hc     <= HW'(HALF_CYC - 1);
      if (!drained) overrun <= 1'b1;
    end else begin
      if (rd_rise && !drained) cnt <= cnt + 1'b1;
      if (!rdy_n) begin
        if (rd_rise || hc == '0) rdy_n <= 1'b1;
        else                     hc    <= hc - 1'b1;
      end
    end

  assign sel       = drained ? IW'(DBITS - 1) : cnt[IW-1:0];
  assign host_data = byte_q[sel];
endmodule

// File: rtl/byte_buffer_rx_chk.sv
module byte_buffer_rx_chk #(
  parameter int HALF_CYC = 20833
) (
  input logic clk,
  input logic rst_n,
  input logic bit_tick,
  input logic carrier_ok,
  input logic host_data,
  input logic rdy_n,
  input logic overrun,
  input logic ld,
  input logic rd
);
  logic [31:0] lowc;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      lowc <= '0;
    else if (ld)     lowc <= '0;
    else if (!rdy_n) lowc <= lowc + 1;
    else             lowc <= '0;

  assert_rdy_after_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> !rdy_n);

  assert_rdy_fall_needs_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rdy_n) |-> ($past(carrier_ok) && $past(bit_tick)));

  assert_data_moves_on_event_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(host_data) |-> ($past(rd) || $past(ld)));

  assert_rdy_low_bounded_R5: assert property (@(posedge clk) disable iff (!rst_n)
    lowc <= HALF_CYC);

  assert_overrun_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);
endmodule

bind byte_buffer_rx byte_buffer_rx_chk #(.HALF_CYC(HALF_CYC)) chk_i (
  .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .carrier_ok(carrier_ok),
  .host_data(host_data), .rdy_n(rdy_n), .overrun(overrun),
  .ld(load_w), .rd(rd_rise)
);

// File: tb/byte_buffer_rx_tb_top.sv
module byte_buffer_rx_tb_top;
  localparam int HALF = 40;
  localparam int GAP  = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bit_tick = 1'b0, rx_bit = 1'b1, carrier_ok = 1'b1, host_clk = 1'b0;
  logic host_data, rdy_n, overrun;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  byte_buffer_rx #(.DBITS(8), .HALF_CYC(HALF)) dut_i (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .rx_bit(rx_bit),
    .carrier_ok(carrier_ok), .host_clk(host_clk),
    .host_data(host_data), .rdy_n(rdy_n), .overrun(overrun)
  );

  function automatic logic eb(input logic [7:0] b, input int k);
    return b[(k > 7) ? 7 : k];
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input logic b);
    repeat (GAP) @(negedge clk);
    rx_bit = b; bit_tick = 1'b1;
    @(negedge clk);
    bit_tick = 1'b0;
  endtask

  task automatic frame_data(input logic [7:0] b);
    tick(1'b0);
    for (int i = 0; i < 8; i++) tick(b[i]);
  endtask

  task automatic rd_pulse();
    host_clk = 1'b1;
    repeat (6) @(negedge clk);
    host_clk = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic read_from(input logic [7:0] b, input int first, input string req);
    for (int k = first; k <= 8; k++) begin
      rd_pulse();
      chk(req, host_data, eb(b, k));
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    logic [7:0] rb;
    void'($urandom(32'd4242));
    do_reset();
    chk("R1 rdy_n", rdy_n, 1);
    chk("R1 overrun", overrun, 0);
    chk("R1 host_data", host_data, 1);

    frame_data(8'hA5);
    chk("R2 rdy_n low", rdy_n, 0);
    chk("R2 first bit", host_data, eb(8'hA5, 0));
    host_clk = 1'b1;
    repeat (2) @(negedge clk);
    chk("R4 before edge rdy", rdy_n, 0);
    chk("R3 before edge data", host_data, eb(8'hA5, 0));
    @(negedge clk);
    chk("R4 cleared by read", rdy_n, 1);
    chk("R3 advanced", host_data, eb(8'hA5, 1));
    repeat (3) @(negedge clk);
    host_clk = 1'b0;
    repeat (6) @(negedge clk);
    read_from(8'hA5, 2, "R3 read order");
    for (int j = 0; j < 3; j++) begin
      rd_pulse();
      chk("R6 extra edge ignored", host_data, eb(8'hA5, 7));
    end
    tick(1'b1);

    frame_data(8'h3C);
    chk("R6 no overrun after full read", overrun, 0);
    repeat (HALF - 1) @(negedge clk);
    chk("R5 still low", rdy_n, 0);
    @(negedge clk);
    chk("R5 released", rdy_n, 1);
    tick(1'b0);
    for (int j = 0; j < 9; j++) tick(1'b1);
    chk("R8 stop not a start rdy", rdy_n, 1);
    chk("R8 stop not a start data", host_data, eb(8'h3C, 0));

    frame_data(8'h96);
    chk("R9 overrun set", overrun, 1);
    chk("R9 new byte shown", host_data, eb(8'h96, 0));
    tick(1'b1);
    read_from(8'h96, 1, "R3 after overrun");
    frame_data(8'h51);
    chk("R9 sticky", overrun, 1);
    tick(1'b1);
    read_from(8'h51, 1, "R3 byte 51");

    do_reset();
    chk("R1 overrun cleared", overrun, 0);
    carrier_ok = 1'b0;
    frame_data(8'h00);
    chk("R7 no rdy without carrier", rdy_n, 1);
    chk("R7 data unchanged", host_data, 1);
    carrier_ok = 1'b1;
    tick(1'b0);
    for (int j = 0; j < 4; j++) tick(1'b0);
    @(negedge clk); carrier_ok = 1'b0;
    @(negedge clk); carrier_ok = 1'b1;
    for (int j = 0; j < 5; j++) tick(1'b1);
    chk("R7 partial word dropped", rdy_n, 1);
    chk("R7 partial data unchanged", host_data, 1);

    for (int n = 0; n < 12; n++) begin
      rb = 8'($urandom);
      frame_data(rb);
      chk("R2 random rdy", rdy_n, 0);
      chk("R2 random first bit", host_data, eb(rb, 0));
      chk("R9 no overrun", overrun, 0);
      tick(1'b1);
      if ($urandom % 2) repeat (HALF + 5) @(negedge clk);
      read_from(rb, 1, "R3 random read");
      rd_pulse();
      chk("R6 random extra edge", host_data, eb(rb, 7));
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule